// File: doc/BRIEF.md
# I2C Target Inactivity Timeout Watchdog

This block sits beside an I2C target engine in a bus with more than one controller. If a peer controller walks away from the bus partway through a transfer, the target engine can be left in a non-idle state with no further clock or data edges to move it on. The watchdog measures how long the target has been busy with no bus activity. When that time reaches a programmed limit, it sends the engine a one-cycle forced-idle pulse and raises a sticky interrupt status flag.

The limit is the product of a prescaled tick and a tick count. One tick is 2^BASE_LOG2 × 4^d system clocks. With the default BASE_LOG2 of 14 this gives 16384, 65536, 262144 or 1048576 clocks for d = 0..3. The tick count is 5 bits, and a count of zero turns the watchdog off. Software configures the block through a small word-addressed write port with four registers, and reads them back through a combinational read port. The interrupt line is the status flag gated by its enable bit.

The control is a four-state machine:
- WD_IDLE moves to WD_COUNT when the target is busy and the count is non-zero.
- WD_COUNT returns to WD_IDLE when the target leaves busy or the count becomes zero. It stays in WD_COUNT with both counters cleared on a bus-activity strobe or a timing-register write. It moves to WD_FIRE when the last tick of the programmed count ends.
- WD_FIRE lasts exactly one cycle. It moves to WD_HOLD if the target is still busy, and to WD_IDLE otherwise.
- WD_HOLD keeps the counters at zero and returns to WD_IDLE once busy drops.

Top module: `i2c_tgt_idle_wdog`

## Requirements
- R1: After a synchronous active-high reset, all four registers read zero, and forced_idle_o and irq_o are low. The timeout is therefore disabled.
- R2: Register address 0 holds the tick exponent d in bits [9:8]. One tick is 2^BASE_LOG2 × 4^d clocks, and the field reads back as written.
- R3: Register address 1 holds the tick count C in bits [4:0], and the field reads back as written. If busy_i is first sampled high at edge P with no restart, forced_idle_o is high for exactly the one cycle after edge P + C × tick.
- R4: A tick count of zero disables the watchdog: no forced-idle pulse occurs however long busy_i stays high.
- R5: An act_i strobe sampled at edge Q while counting restarts the timeout, so the pulse follows edge Q + C × tick.
- R6: busy_i sampled low clears both counters. A later busy period times out in full from its own start.
- R7: Each timeout gives exactly one pulse. While busy_i stays high afterwards, no further pulse occurs until busy_i has dropped.
- R8: A timeout sets the status flag in bit 15 of address 3 at the edge after the pulse cycle. Writing 1 to bit 15 of address 3 clears it, and writing other bits has no effect. A timeout in the same cycle as a clear leaves the flag set.
- R9: irq_o is high exactly when the status flag and the enable bit (bit 15 of address 2) are both set.
- R10: A write to address 0 or address 1 while counting restarts both counters from the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Target engine is in a non-idle state |
| act_i | input | 1 | One-cycle strobe on any SCL or SDA edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| forced_idle_o | output | 1 | One-cycle pulse that returns the target engine to idle |
| irq_o | output | 1 | Inactivity-timeout interrupt |

## Verification
The bench predicts the exact cycle of every forced-idle pulse and compares it against what the design produces. It covers every tick exponent, including the largest count, and restarts from an activity strobe, a busy drop and a configuration write. A design that failed to restart on any of these would fire early and miss its predicted cycle. A design that re-armed while busy stayed high would produce an unexpected second pulse. The bench also checks that a zero count never fires, that writes to other status bits leave the flag alone, and that a clear landing on the timeout edge does not drop the flag.

// File: rtl/i2c_wdog_pkg.sv
package i2c_wdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRE  = 2'd2,
        WD_HOLD  = 2'd3
    } wd_state_e;

    localparam int unsigned ADDR_TIM_A = 0;
    localparam int unsigned ADDR_TIM_B = 1;
    localparam int unsigned ADDR_IEN   = 2;
    localparam int unsigned ADDR_ISTAT = 3;

    localparam int unsigned DIV_LSB = 8;
    localparam int unsigned CNT_LSB = 0;
    localparam int unsigned IRQ_BIT = 15;

endpackage

// File: rtl/wdog_cfg_regs.sv
module wdog_cfg_regs
    import i2c_wdog_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DIV_W  = 2,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              fire_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ien_o,
    output logic              istat_o,
    output logic              cfg_wr_o
);

    logic wr_tim_a, wr_tim_b, wr_ien, wr_istat;
    logic unused_wr_bits;

    assign wr_tim_a = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_TIM_A));
    assign wr_tim_b = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_TIM_B));
    assign wr_ien   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_IEN));
    assign wr_istat = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_ISTAT));
    assign cfg_wr_o = wr_tim_a || wr_tim_b;
    assign unused_wr_bits = ^wr_data_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_o   <= '0;
            cnt_o   <= '0;
            ien_o   <= 1'b0;
            istat_o <= 1'b0;
        end else begin
            if (wr_tim_a) div_o <= wr_data_i[DIV_LSB +: DIV_W];
            if (wr_tim_b) cnt_o <= wr_data_i[CNT_LSB +: CNT_W];
            if (wr_ien)   ien_o <= wr_data_i[IRQ_BIT];
            if (fire_i)
                istat_o <= 1'b1;
            else if (wr_istat && wr_data_i[IRQ_BIT])
                istat_o <= 1'b0;
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_W'(ADDR_TIM_A): rd_data_o[DIV_LSB +: DIV_W] = div_o;
            ADDR_W'(ADDR_TIM_B): rd_data_o[CNT_LSB +: CNT_W] = cnt_o;
            ADDR_W'(ADDR_IEN):   rd_data_o[IRQ_BIT]          = ien_o;
            default:             rd_data_o[IRQ_BIT]          = istat_o;
        endcase
    end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned BASE_LOG2 = 14,
    parameter int unsigned DIV_W     = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int unsigned DIV_MAX = (1 << DIV_W) - 1;
    localparam int unsigned PRE_W   = BASE_LOG2 + 2 * DIV_MAX;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    always_comb begin
        span  = (PRE_W+1)'(1) << (BASE_LOG2 + 2 * int'(div_i));
        limit = span[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
    end

    assign tick_o = run_i && (pre_q == limit);

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i || tick_o)
            pre_q <= '0;
        else
            pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import i2c_wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             busy_i,
    input  logic             act_i,
    input  logic             cfg_wr_i,
    input  logic [CNT_W-1:0] cnt_cfg_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic             fire_o
);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] tick_cnt_q;
    logic             enabled, restart, last_tick;

    assign enabled   = (cnt_cfg_i != '0);
    assign restart   = act_i || cfg_wr_i;
    assign last_tick = tick_i && (tick_cnt_q == cnt_cfg_i - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  if (busy_i && enabled) state_d = WD_COUNT;
            WD_COUNT: begin
                if (!busy_i || !enabled) state_d = WD_IDLE;
                else if (restart)        state_d = WD_COUNT;
                else if (last_tick)      state_d = WD_FIRE;
            end
            WD_FIRE:  state_d = busy_i ? WD_HOLD : WD_IDLE;
            WD_HOLD:  if (!busy_i) state_d = WD_IDLE;
            default:  state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= WD_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        run_o  = (state_q == WD_COUNT) && busy_i && enabled && !restart;
        fire_o = (state_q == WD_FIRE);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_o)
            tick_cnt_q <= '0;
        else if (tick_i)
            tick_cnt_q <= tick_cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/i2c_tgt_idle_wdog.sv
module i2c_tgt_idle_wdog #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DIV_W     = 2,
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned BASE_LOG2 = 14
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              busy_i,
    input  logic              act_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              forced_idle_o,
    output logic              irq_o
);

    logic [DIV_W-1:0] div_cfg;
    logic [CNT_W-1:0] cnt_cfg;
    logic             irq_en, irq_status, cfg_wr;
    logic             run, tick, fire;

    wdog_cfg_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk_i(clk_i), .rst_i(rst_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .fire_i(fire),
        .div_o(div_cfg), .cnt_o(cnt_cfg),
        .ien_o(irq_en), .istat_o(irq_status), .cfg_wr_o(cfg_wr)
    );

    wdog_prescaler #(
        .BASE_LOG2(BASE_LOG2), .DIV_W(DIV_W)
    ) u_pre (
        .clk_i(clk_i), .rst_i(rst_i),
        .run_i(run), .div_i(div_cfg), .tick_o(tick)
    );

    wdog_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk_i(clk_i), .rst_i(rst_i),
        .busy_i(busy_i), .act_i(act_i), .cfg_wr_i(cfg_wr),
        .cnt_cfg_i(cnt_cfg), .tick_i(tick),
        .run_o(run), .fire_o(fire)
    );

    assign forced_idle_o = fire;
    assign irq_o         = irq_status && irq_en;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             busy_i,
    input logic             act_i,
    input logic             forced_idle_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt_cfg,
    input logic             irq_en,
    input logic             irq_status
);

    assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        forced_idle_o |=> !forced_idle_o);

    assert_status_set_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        forced_idle_o |=> irq_status);

    assert_zero_count_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        forced_idle_o |-> (cnt_cfg != '0));

    assert_needs_busy_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        forced_idle_o |-> $past(busy_i));

    assert_activity_restarts_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        forced_idle_o |-> !$past(act_i));

    assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !irq_en |-> !irq_o);

endmodule

bind i2c_tgt_idle_wdog wdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .busy_i(busy_i), .act_i(act_i),
    .forced_idle_o(forced_idle_o), .irq_o(irq_o),
    .cnt_cfg(cnt_cfg), .irq_en(irq_en), .irq_status(irq_status)
);

// File: tb/i2c_tgt_idle_wdog_tb_top.sv
module i2c_tgt_idle_wdog_tb_top;

    localparam int B = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy = 1'b0, act = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        fidle, irq;

    int cyc = 0, nchk = 0, nerr = 0, npulse = 0, npush = 0, last_edge = 0;
    int exp_q[$];

    i2c_tgt_idle_wdog #(.BASE_LOG2(B)) dut_i (
        .clk_i(clk), .rst_i(rst), .busy_i(busy), .act_i(act),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .forced_idle_o(fidle), .irq_o(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
        nchk++;
        if (a !== e) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    // monitor: pops the expected pulse cycle and compares
    always @(negedge clk) begin
        if (!rst && fidle) begin
            npulse++;
            nchk++;
            if (exp_q.size() == 0) begin
                nerr++;
                $display("FAIL R7 unexpected pulse actual=%0d expected=none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    nerr++;
                    $display("FAIL R3 pulse cycle actual=%0d expected=%0d", cyc, e);
                end
            end
        end
    end

    task automatic push_exp(input int e);
        exp_q.push_back(e);
        npush++;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        last_edge = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic busy_on(input int n, input bit do_push);
        @(negedge clk);
        busy = 1'b1;
        if (do_push) push_exp(cyc + 1 + n);
    endtask

    task automatic wait_pulse();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        idle(5);
        rst = 1'b0;
        idle(1);
        // R1: reset state
        chk("R1 forced_idle", {31'b0, fidle}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 0);
        end

        // R3: basic timeout, count 3, d=0 -> 48 clocks
        wr(2'd1, 32'd3);
        wr(2'd0, 32'd0);
        rd(2'd1, d); chk("R3 count readback", d, 32'd3);
        busy_on(3 * 16, 1'b1);
        wait_pulse();
        rd(2'd3, d); chk("R8 status set", d, 32'h8000);
        chk("R9 irq masked", {31'b0, irq}, 0);
        // R7: stay busy, no second pulse
        idle(200);
        chk("R7 single pulse", npulse, 1);
        busy = 1'b0;
        idle(2);

        // R9 / R8: enable, then clear
        wr(2'd2, 32'h8000);
        idle(1);
        chk("R9 irq asserted", {31'b0, irq}, 1);
        wr(2'd3, 32'h0000_7fff);
        rd(2'd3, d); chk("R8 other bits no clear", d, 32'h8000);
        wr(2'd3, 32'h8000);
        rd(2'd3, d); chk("R8 w1c", d, 0);
        chk("R9 irq cleared", {31'b0, irq}, 0);

        // R2: tick exponents
        for (int k = 1; k <= 3; k++) begin
            int c, n;
            c = (k == 3) ? 31 : (k == 1 ? 2 : 1);
            n = c * (16 << (2 * k));
            wr(2'd0, 32'(k) << 8);
            wr(2'd1, 32'(c));
            rd(2'd0, d); chk("R2 exponent readback", d, 32'(k) << 8);
            rd(2'd1, d); chk("R3 count readback", d, 32'(c));
            busy_on(n, 1'b1);
            wait_pulse();
            chk("R2 irq after scaled timeout", {31'b0, irq}, 1);
            busy = 1'b0;
            wr(2'd3, 32'h8000);
        end

        // R5: activity strobe restarts
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd2);
        busy_on(0, 1'b0);
        idle(20);
        act = 1'b1;
        push_exp(cyc + 1 + 32);
        @(negedge clk);
        act = 1'b0;
        wait_pulse();
        chk("R5 pulse after activity", npulse, npush);
        busy = 1'b0;
        idle(2);

        // R6: busy drop clears
        busy_on(0, 1'b0);
        idle(25);
        busy = 1'b0;
        @(negedge clk);
        busy = 1'b1;
        push_exp(cyc + 1 + 32);
        wait_pulse();
        chk("R6 pulse after busy drop", npulse, npush);
        busy = 1'b0;
        idle(2);

        // R10: timing write restarts
        busy_on(0, 1'b0);
        idle(20);
        wr(2'd1, 32'd2);
        push_exp(last_edge + 32);
        idle(10);
        wr(2'd0, 32'd0);
        exp_q.delete(); npush--;
        push_exp(last_edge + 32);
        wait_pulse();
        chk("R10 pulse after config write", npulse, npush);
        busy = 1'b0;
        wr(2'd3, 32'h8000);

        // R4: zero count disables
        wr(2'd1, 32'd0);
        busy_on(0, 1'b0);
        idle(3000);
        chk("R4 no pulse when disabled", npulse, npush);
        rd(2'd3, d); chk("R4 status stays clear", d, 0);
        busy = 1'b0;
        idle(2);

        // R8: timeout wins over a same-cycle clear
        wr(2'd1, 32'd1);
        busy_on(16, 1'b1);
        @(negedge clk);
        while (!fidle) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h8000;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd3, d); chk("R8 set beats clear", d, 32'h8000);
        busy = 1'b0;
        idle(4);

        chk("R7 queue drained", exp_q.size(), 0);
        chk("R7 pulse total", npulse, npush);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule